// File: doc/BRIEF.md
# Burst Read Wrapping Address Generator

This block sits behind the command decoder of a serial flash model and turns decoded command events into a stream of byte addresses for the data path. A set-burst-length command is followed by one data byte whose two low bits pick a wrap window of 8, 16, 32 or 64 bytes. A wrapping burst read supplies a 24-bit start address and, after its dummy cycle, a dummy-done pulse. From then on the block streams addresses. The low bits of each address count upward modulo the window length, and the high bits stay fixed. The stream continues until chip-select goes high.

The same counter also drives two other continuous reads. In the three-byte ID read it produces a byte index that cycles 0, 1, 2, 0, ... The status read produces index 0 on every byte. A source tag tells the data path which space the address refers to. The output is a valid/ready stream. `rd_valid` stays high in every streaming state while chip-select is low. One address is consumed on each cycle where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, the address holds. Raising chip-select drops `rd_valid` in the same cycle and aborts whatever command was in progress.

Top module: `burst_wrap_addr_gen`

## Requirements
- R1: After reset, `rd_valid` is 0 and the wrap length code is 0 (8-byte window).
- R2: Opcode C0h, followed by a `data_valid` byte while chip-select stays low, loads the byte's bits [1:0] as the length code. Code 0 selects 8 bytes, 1 selects 16, 2 selects 32 and 3 selects 64. Bits [7:2] are ignored.
- R3: Opcode 0Ch takes one `addr_valid` start address and then one `dummy_done` pulse. In the cycle after that pulse, `rd_valid` is 1, `rd_src` is 0 (array) and `rd_addr` equals the start address.
- R4: In an array stream, each accepted address is followed by an address whose low log2(window) bits are the previous low bits plus one, modulo the window. The remaining high bits are unchanged.
- R5: While `rd_valid` is 1 and `rd_ready` is 0, `rd_addr` and `rd_valid` hold in the next cycle, provided chip-select stays low.
- R6: Opcode AFh starts a stream with `rd_src` = 1. `rd_addr` starts at 0 and, on each accepted byte, steps 0, 1, 2 and back to 0.
- R7: Opcode 05h starts a stream with `rd_src` = 2 and `rd_addr` = 0 on every byte, for as long as chip-select stays low.
- R8: When `cs_n` is 1, `rd_valid` is 0 in that same cycle and the block returns to idle. A C0h command cut off before its data byte leaves the length code unchanged.
- R9: Only the first opcode after chip-select falls is acted on. Any later `op_valid` is ignored until chip-select rises. An unrecognised opcode produces no stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low; high ends any command |
| op_valid | input | 1 | Opcode byte present on `op_code` |
| op_code | input | 8 | Decoded command byte |
| data_valid | input | 1 | Data byte present (used by set-burst-length) |
| data_byte | input | 8 | Data byte; bits [1:0] carry the length code |
| addr_valid | input | 1 | Start address present on `addr_in` |
| addr_in | input | 24 | Start address of a wrapping burst |
| dummy_done | input | 1 | Dummy cycle of the burst read has ended |
| rd_valid | output | 1 | An address is offered |
| rd_ready | input | 1 | Data path takes the offered address |
| rd_addr | output | 24 | Byte address or ID/status index |
| rd_src | output | 2 | 0 array, 1 ID bytes, 2 status |

## Verification
Array bursts run at every window length. Start addresses are chosen so that the first wrap happens after one byte, in mid-window and at the very top of the address space. Together these show whether a carry leaks into the high bits. One burst uses a stalling `rd_ready` pattern, which separates holding the address from advancing it. Other runs cut a length command off before its data byte, give the length command a data byte with junk in its upper bits, issue a second opcode inside one select, and drop chip-select mid-stream. These show whether the length register, the command gating and the abort path behave independently of the counter.

// File: rtl/burst_wrap_pkg.sv
package burst_wrap_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_ID     = 2'd1,
    SRC_STATUS = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    CNT_POW2 = 2'd0,
    CNT_MODN = 2'd1,
    CNT_HOLD = 2'd2
  } cnt_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LEN    = 3'd1,
    ST_ADDR   = 3'd2,
    ST_DUMMY  = 3'd3,
    ST_ARRAY  = 3'd4,
    ST_ID     = 3'd5,
    ST_STATUS = 3'd6,
    ST_HOLD   = 3'd7
  } state_e;

endpackage

// File: rtl/burst_len_reg.sv
module burst_len_reg #(
  parameter int ADDR_W   = 24,
  parameter int CODE_W   = 2,
  parameter int MIN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [ADDR_W-1:0] win_mask
);

  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     code_q <= '0;
    else if (wr_en) code_q <= wr_code;
  end

  // One mask bit per address bit: set below log2 of the window.
  for (genvar g = 0; g < ADDR_W; g++) begin : g_mask
    assign win_mask[g] = (g < (MIN_LOG2 + int'(code_q)));
  end

  assert_len_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(code_q));

endmodule

// File: rtl/wrap_counter.sv
module wrap_counter
  import burst_wrap_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int ID_N   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  cnt_mode_e         mode,
  input  logic [ADDR_W-1:0] mask,
  output logic [ADDR_W-1:0] q
);

  localparam logic [ADDR_W-1:0] ID_LAST = ADDR_W'(ID_N - 1);

  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] nxt;

  assign inc = q + 1'b1;

  always_comb begin
    case (mode)
      CNT_POW2: nxt = (q & ~mask) | (inc & mask);
      CNT_MODN: nxt = (q == ID_LAST) ? '0 : inc;
      default:  nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= nxt;
  end

  assert_high_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode == CNT_POW2) |=> (((q ^ $past(q)) & ~$past(mask)) == '0));

  assert_id_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == CNT_MODN) |-> (q <= ID_LAST));

endmodule

// File: rtl/burst_cmd_fsm.sv
module burst_cmd_fsm
  import burst_wrap_pkg::*;
#(
  parameter int          ADDR_W       = 24,
  parameter int          CODE_W       = 2,
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  OP_SET_LEN   = 8'hC0,
  parameter logic [7:0]  OP_WRAP_READ = 8'h0C,
  parameter logic [7:0]  OP_ID_READ   = 8'hAF,
  parameter logic [7:0]  OP_STATUS    = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              dummy_done,
  input  logic              out_ready,
  output logic              len_wr,
  output logic [CODE_W-1:0] len_code,
  output logic              cnt_load,
  output logic [ADDR_W-1:0] cnt_load_val,
  output logic              cnt_step,
  output cnt_mode_e         cnt_mode,
  output logic              out_valid,
  output src_e              out_src
);

  state_e st, st_nxt;
  logic   streaming;

  always_comb begin
    st_nxt       = st;
    len_wr       = 1'b0;
    cnt_load     = 1'b0;
    cnt_load_val = '0;
    if (cs_n) begin
      st_nxt = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: if (op_valid) begin
          if (op_code == OP_SET_LEN)        st_nxt = ST_LEN;
          else if (op_code == OP_WRAP_READ) st_nxt = ST_ADDR;
          else if (op_code == OP_ID_READ) begin
            st_nxt   = ST_ID;
            cnt_load = 1'b1;
          end else if (op_code == OP_STATUS) begin
            st_nxt   = ST_STATUS;
            cnt_load = 1'b1;
          end else                          st_nxt = ST_HOLD;
        end
        ST_LEN: if (data_valid) begin
          len_wr = 1'b1;
          st_nxt = ST_HOLD;
        end
        ST_ADDR: if (addr_valid) begin
          cnt_load     = 1'b1;
          cnt_load_val = addr_in;
          st_nxt       = ST_DUMMY;
        end
        ST_DUMMY: if (dummy_done) st_nxt = ST_ARRAY;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign len_code  = data_byte[CODE_W-1:0];
  assign streaming = (st == ST_ARRAY) || (st == ST_ID) || (st == ST_STATUS);
  assign out_valid = streaming && !cs_n;
  assign cnt_step  = out_valid && out_ready;

  always_comb begin
    case (st)
      ST_ID:     begin out_src = SRC_ID;     cnt_mode = CNT_MODN; end
      ST_STATUS: begin out_src = SRC_STATUS; cnt_mode = CNT_HOLD; end
      ST_ARRAY:  begin out_src = SRC_ARRAY;  cnt_mode = CNT_POW2; end
      default:   begin out_src = SRC_ARRAY;  cnt_mode = CNT_HOLD; end
    endcase
  end

  assert_cs_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st == ST_IDLE));

  assert_no_reop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE && !cs_n) |=> (st != ST_IDLE));

endmodule

// File: rtl/burst_wrap_addr_gen.sv
module burst_wrap_addr_gen
  import burst_wrap_pkg::*;
#(
  parameter int         ADDR_W       = 24,
  parameter int         CODE_W       = 2,
  parameter int         MIN_LOG2     = 3,
  parameter int         ID_N         = 3,
  parameter logic [7:0] OP_SET_LEN   = 8'hC0,
  parameter logic [7:0] OP_WRAP_READ = 8'h0C,
  parameter logic [7:0] OP_ID_READ   = 8'hAF,
  parameter logic [7:0] OP_STATUS    = 8'h05
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic              data_valid,
  input  logic [7:0]        data_byte,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              dummy_done,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_src
);

  localparam int DATA_W = 8;

  logic              len_wr;
  logic [CODE_W-1:0] len_code;
  logic [ADDR_W-1:0] win_mask;
  logic              cnt_load;
  logic [ADDR_W-1:0] cnt_load_val;
  logic              cnt_step;
  cnt_mode_e         cnt_mode;
  src_e              src;

  burst_cmd_fsm #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .DATA_W(DATA_W),
    .OP_SET_LEN(OP_SET_LEN), .OP_WRAP_READ(OP_WRAP_READ),
    .OP_ID_READ(OP_ID_READ), .OP_STATUS(OP_STATUS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .op_valid(op_valid), .op_code(op_code),
    .data_valid(data_valid), .data_byte(data_byte),
    .addr_valid(addr_valid), .addr_in(addr_in),
    .dummy_done(dummy_done), .out_ready(rd_ready),
    .len_wr(len_wr), .len_code(len_code),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
    .cnt_step(cnt_step), .cnt_mode(cnt_mode),
    .out_valid(rd_valid), .out_src(src)
  );

  burst_len_reg #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2)
  ) u_len (
    .clk(clk), .rst_n(rst_n), .wr_en(len_wr), .wr_code(len_code),
    .win_mask(win_mask)
  );

  wrap_counter #(
    .ADDR_W(ADDR_W), .ID_N(ID_N)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_load_val),
    .step(cnt_step), .mode(cnt_mode), .mask(win_mask), .q(rd_addr)
  );

  assign rd_src = src;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (cs_n || (rd_valid && rd_addr == $past(rd_addr))));

  assert_status_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_src == 2'd2) |-> (rd_addr == '0));

endmodule

// File: tb/burst_wrap_addr_gen_tb_top.sv
module burst_wrap_addr_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic        data_valid = 1'b0;
  logic [7:0]  data_byte = 8'h00;
  logic        addr_valid = 1'b0;
  logic [23:0] addr_in = 24'h0;
  logic        dummy_done = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [23:0] rd_addr;
  logic [1:0]  rd_src;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  always #2 clk = ~clk;

  burst_wrap_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .op_valid(op_valid), .op_code(op_code),
    .data_valid(data_valid), .data_byte(data_byte),
    .addr_valid(addr_valid), .addr_in(addr_in),
    .dummy_done(dummy_done), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_src(rd_src)
  );

  // Behavioural reference: 0 idle, 1 len, 2 addr, 3 dummy, 4 array, 5 id, 6 status, 7 hold
  int          mst;
  int          mlen;
  logic [23:0] ma;

  always @(posedge clk) begin
    int w;
    if (!rst_n) begin
      mst = 0; mlen = 0; ma = 0;
    end else if (cs_n) begin
      mst = 0;
    end else begin
      case (mst)
        0: if (op_valid) begin
          if (op_code == 8'hC0) mst = 1;
          else if (op_code == 8'h0C) mst = 2;
          else if (op_code == 8'hAF) begin mst = 5; ma = 0; end
          else if (op_code == 8'h05) begin mst = 6; ma = 0; end
          else mst = 7;
        end
        1: if (data_valid) begin mlen = data_byte % 4; mst = 7; end
        2: if (addr_valid) begin ma = addr_in; mst = 3; end
        3: if (dummy_done) mst = 4;
        4: if (rd_ready) begin
          w  = 8 << mlen;
          ma = (ma & ~24'(w - 1)) | ((ma + 24'd1) & 24'(w - 1));
        end
        5: if (rd_ready) ma = (ma == 24'd2) ? 24'd0 : ma + 24'd1;
        default: ;
      endcase
    end
  end

  task automatic check(input string req, input logic ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    logic ev;
    logic [1:0] es;
    ev = (mst >= 4 && mst <= 6) && !cs_n;
    es = (mst == 5) ? 2'd1 : (mst == 6) ? 2'd2 : 2'd0;
    check(phase, rd_valid === ev, {31'd0, rd_valid}, {31'd0, ev});
    if (ev) begin
      check(phase, rd_addr === ma, {8'd0, rd_addr}, {8'd0, ma});
      check(phase, rd_src === es, {30'd0, rd_src}, {30'd0, es});
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic send_op(input logic [7:0] op);
    op_valid = 1'b1; op_code = op;
    cyc();
    op_valid = 1'b0;
  endtask

  task automatic end_cs();
    rd_ready = 1'b0;
    cs_n = 1'b1;
    @(negedge clk);
    check("R8", rd_valid === 1'b0, {31'd0, rd_valid}, 32'd0);
    cyc();
    cyc();
  endtask

  task automatic set_len(input logic [7:0] b, input bit abort);
    cs_n = 1'b0; cyc();
    send_op(8'hC0);
    if (abort) begin
      cs_n = 1'b1; data_valid = 1'b1; data_byte = 8'h00;
      cyc();
      data_valid = 1'b0;
    end else begin
      data_valid = 1'b1; data_byte = b;
      cyc();
      data_valid = 1'b0;
    end
    end_cs();
  endtask

  task automatic burst(input logic [23:0] start, input int n, input bit stall);
    logic [23:0] prev;
    cs_n = 1'b0; cyc();
    send_op(8'h0C);
    addr_valid = 1'b1; addr_in = start;
    cyc();
    addr_valid = 1'b0;
    dummy_done = 1'b1;
    cyc();
    dummy_done = 1'b0;
    check("R3", rd_valid === 1'b1 && rd_addr === start, {8'd0, rd_addr}, {8'd0, start});
    for (int i = 0; i < n; i++) begin
      rd_ready = stall ? ((i % 3) != 1) : 1'b1;
      prev = rd_addr;
      cyc();
      if (!rd_ready)
        check("R5", rd_addr === prev, {8'd0, rd_addr}, {8'd0, prev});
      if (i == n / 2) begin
        op_valid = 1'b1; op_code = 8'hAF;  // R9: ignored mid-stream
      end else begin
        op_valid = 1'b0;
      end
    end
    op_valid = 1'b0;
    end_cs();
  endtask

  task automatic stream(input logic [7:0] op, input int n);
    cs_n = 1'b0; cyc();
    send_op(op);
    for (int i = 0; i < n; i++) begin
      rd_ready = ((i % 4) != 2);
      cyc();
    end
    end_cs();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc();
    phase = "R1";
    check("R1", rd_valid === 1'b0, {31'd0, rd_valid}, 32'd0);

    phase = "R4";                       // default 8-byte window (R1)
    burst(24'h12345E, 12, 1'b0);
    burst(24'h000007, 10, 1'b0);

    phase = "R2";                       // junk upper bits, code 2 -> 32
    set_len(8'hFE, 1'b0);
    burst(24'h00ABFC, 40, 1'b0);

    phase = "R5";                       // code 3 -> 64 with stalls
    set_len(8'h03, 1'b0);
    burst(24'hFFFFF0, 90, 1'b1);

    phase = "R8";                       // aborted length write keeps 64
    set_len(8'h01, 1'b1);
    burst(24'h40003E, 70, 1'b0);

    phase = "R6";
    stream(8'hAF, 11);

    phase = "R7";
    stream(8'h05, 7);

    phase = "R9";
    cs_n = 1'b0; cyc();
    send_op(8'h9F);
    send_op(8'h0C);
    addr_valid = 1'b1; addr_in = 24'h000100; cyc(); addr_valid = 1'b0;
    dummy_done = 1'b1; rd_ready = 1'b1; cyc(); dummy_done = 1'b0;
    repeat (3) cyc();
    check("R9", rd_valid === 1'b0, {31'd0, rd_valid}, 32'd0);
    end_cs();

    phase = "R2";                       // code 1 -> 16
    set_len(8'h01, 1'b0);
    burst(24'h00000F, 20, 1'b1);

    phase = "R8";                       // chip-select drop mid-stream
    cs_n = 1'b0; cyc();
    send_op(8'h0C);
    addr_valid = 1'b1; addr_in = 24'h000020; cyc(); addr_valid = 1'b0;
    dummy_done = 1'b1; cyc(); dummy_done = 1'b0;
    rd_ready = 1'b1; cyc(); cyc();
    end_cs();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule